// File: doc/BRIEF.md
# Load Grant and Store Release Ordering Gate

This block sits beside a reorder buffer in an out-of-order core and decides, every cycle, whether the load being considered may read memory. It keeps a small record per reorder-buffer slot of the stores in flight. For each store it holds whether the slot is occupied, whether its address is known yet, the address and the store data. A load presents its slot index and effective address. Every occupied store slot that is older than the load is compared with it, with age measured circularly from the head pointer. The load is held back if any such store matches its address exactly or has no address yet.

Stores never write memory while they execute. A store is offered to memory only when its slot is the reorder-buffer head and its address is resolved, through a valid/ready handshake. A completed handshake frees the slot. Memory writes therefore happen strictly in program order, and write-after-write and write-after-read hazards through memory cannot arise. A flush discards every recorded store, and none of the discarded stores is ever offered to memory. DEPTH must be a power of two.

Top module: `ld_st_order_gate`

## Requirements
- R1: After reset no store is recorded: `mem_wr_vld` is 0 and a load with `ld_vld`=1 is granted at any address.
- R2: A load is refused (`ld_grant`=0) while an occupied store slot that is older than the load holds a resolved address equal, over the full width, to `ld_addr`.
- R3: A load is refused while an occupied store slot older than it has not yet received its address.
- R4: An older store with a resolved address that differs from `ld_addr` in any bit does not refuse the load.
- R5: Age is circular: slot s is older than load slot l when (s - `rob_head`) mod DEPTH < (l - `rob_head`) mod DEPTH. Stores in the load's own slot or in younger slots never refuse it, including across the wrap of the slot index.
- R6: `mem_wr_vld` is 1 exactly when the `rob_head` slot holds a store whose address is resolved and `flush` is 0. `mem_wr_addr`/`mem_wr_data` then carry that store's address and data.
- R7: While `mem_wr_rdy` is 0 the release is held with a stable address. A cycle with `mem_wr_vld` and `mem_wr_rdy` both 1 frees the head slot, so the offer is gone in the next cycle.
- R8: `flush` discards all recorded stores in the cycle it is high. `mem_wr_vld` is 0 during that cycle and afterwards, until a store is recorded and resolved again.
- R9: The grant is recomputed every cycle. A load refused by a store is granted in the cycle after that store is released.
- R10: `ld_grant` is 0 whenever `ld_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all recorded stores |
| rob_head | input | IW | Slot index of the oldest reorder-buffer entry |
| st_alloc_vld | input | 1 | A store is placed into slot `st_alloc_idx`, address unknown |
| st_alloc_idx | input | IW | Slot of the newly placed store |
| st_addr_vld | input | 1 | Address and data of a recorded store are resolved |
| st_addr_idx | input | IW | Slot whose address is resolved |
| st_addr | input | AW | Resolved store address |
| st_data | input | DW | Store data |
| ld_vld | input | 1 | A load asks for memory access |
| ld_idx | input | IW | Slot of the load |
| ld_addr | input | AW | Effective address of the load |
| ld_grant | output | 1 | Load may access memory this cycle |
| mem_wr_vld | output | 1 | Head store offered to memory |
| mem_wr_addr | output | AW | Address of the offered store |
| mem_wr_data | output | DW | Data of the offered store |
| mem_wr_rdy | input | 1 | Memory accepts the offered store |

## Verification
The bench builds the gate with DEPTH=8, AW=8 and DW=8. The 3-bit slot index lets the head pointer sit mid-ring, so stores in slots 0 and 7 are placed on opposite sides of the wrap relative to several loads. Every load position from the head to the slot before it can be queried against one fixed set of stores. The narrow addresses keep matching and near-miss addresses easy to write, while the comparison still runs over the full width.

// File: rtl/ld_st_order_gate.sv
module ld_st_order_gate #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [IW-1:0] rob_head,
  input  logic          st_alloc_vld,
  input  logic [IW-1:0] st_alloc_idx,
  input  logic          st_addr_vld,
  input  logic [IW-1:0] st_addr_idx,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_vld,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_grant,
  output logic          mem_wr_vld,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          mem_wr_rdy
);

  logic [DEPTH-1:0] busy, known, hit;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [IW-1:0]    ld_age;
  logic             release_now;

  assign ld_age = ld_idx - rob_head;

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    localparam logic [IW-1:0] SLOT = IW'(j);
    logic [IW-1:0] age;
    assign age    = SLOT - rob_head;
    assign hit[j] = busy[j] && (age < ld_age) && (!known[j] || addr_q[j] == ld_addr);
  end

  assign ld_grant    = ld_vld && !(|hit);
  assign mem_wr_vld  = !flush && busy[rob_head] && known[rob_head];
  assign mem_wr_addr = addr_q[rob_head];
  assign mem_wr_data = data_q[rob_head];
  assign release_now = mem_wr_vld && mem_wr_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      busy  <= '0;
      known <= '0;
    end else begin
      if (release_now) busy[rob_head] <= 1'b0;
      if (st_alloc_vld) begin
        busy[st_alloc_idx]  <= 1'b1;
        known[st_alloc_idx] <= 1'b0;
      end
      if (st_addr_vld) known[st_addr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st_addr_vld) begin
      addr_q[st_addr_idx] <= st_addr;
      data_q[st_addr_idx] <= st_data;
    end
  end

endmodule

// File: rtl/ld_st_order_chk.sv
module ld_st_order_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [IW-1:0] rob_head,
  input logic          ld_vld,
  input logic [IW-1:0] ld_idx,
  input logic [AW-1:0] ld_addr,
  input logic          ld_grant,
  input logic          mem_wr_vld,
  input logic [AW-1:0] mem_wr_addr,
  input logic          mem_wr_rdy
);

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mem_wr_vld);

  a_r2_head_store_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_grant && mem_wr_vld && rob_head != ld_idx) |-> (mem_wr_addr != ld_addr));

  a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_vld && !mem_wr_rdy && !flush) |=>
      ($stable(rob_head) && !flush) -> (mem_wr_vld && $stable(mem_wr_addr)));

  a_r7_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_vld && mem_wr_rdy) |=> $stable(rob_head) -> !mem_wr_vld);

  a_r8_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !mem_wr_vld);

  a_r10_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_vld |-> !ld_grant);

endmodule

bind ld_st_order_gate ld_st_order_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .rob_head(rob_head),
  .ld_vld(ld_vld), .ld_idx(ld_idx), .ld_addr(ld_addr), .ld_grant(ld_grant),
  .mem_wr_vld(mem_wr_vld), .mem_wr_addr(mem_wr_addr), .mem_wr_rdy(mem_wr_rdy)
);

// File: tb/test_ld_st_order_gate.sv
module test_ld_st_order_gate;
  localparam int DEPTH = 8, AW = 8, DW = 8, IW = 3;

  logic clk = 0, rst_n = 0, flush = 0;
  logic [IW-1:0] rob_head = 0, st_alloc_idx = 0, st_addr_idx = 0, ld_idx = 0;
  logic st_alloc_vld = 0, st_addr_vld = 0, ld_vld = 0, mem_wr_rdy = 0;
  logic [AW-1:0] st_addr = 0, ld_addr = 0;
  logic [DW-1:0] st_data = 0;
  logic ld_grant, mem_wr_vld;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  ld_st_order_gate #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_ld_st_order_gate (.*);

  // row: req(4) vld(1) idx(3) addr(8) expected grant(1); head = 2
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2, 1'b1, 3'd4, 8'h10, 1'b0},  // R2 slot3 older, same address
    {4'd4, 1'b1, 3'd4, 8'h11, 1'b1},  // R4 one bit differs
    {4'd5, 1'b1, 3'd3, 8'h10, 1'b1},  // R5 own slot does not block
    {4'd5, 1'b1, 3'd1, 8'h30, 1'b0},  // R5 slot0 older across wrap
    {4'd5, 1'b1, 3'd7, 8'h30, 1'b1},  // R5 slot0 younger than slot7
    {4'd2, 1'b1, 3'd6, 8'h50, 1'b0},  // R2 slot5 resolved match
    {4'd5, 1'b1, 3'd6, 8'h40, 1'b1},  // R5 slot7 younger than slot6
    {4'd5, 1'b1, 3'd0, 8'h40, 1'b0},  // R5 slot7 older than slot0
    {4'd5, 1'b1, 3'd2, 8'h10, 1'b1},  // R5 load at head: nothing older
    {4'd10,1'b0, 3'd4, 8'h10, 1'b0},  // R10 no request
    {4'd4, 1'b1, 3'd1, 8'h99, 1'b1}   // R4 all older stores differ
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic alloc(input logic [IW-1:0] s);
    st_alloc_vld = 1; st_alloc_idx = s; step(); st_alloc_vld = 0;
  endtask

  task automatic resolve(input logic [IW-1:0] s, input logic [AW-1:0] a, input logic [DW-1:0] d);
    st_addr_vld = 1; st_addr_idx = s; st_addr = a; st_data = d; step(); st_addr_vld = 0;
  endtask

  task automatic query(input logic [IW-1:0] s, input logic [AW-1:0] a);
    ld_vld = 1; ld_idx = s; ld_addr = a; @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    query(3'd4, 8'h10);
    chk("R1 grant", ld_grant, 1);
    chk("R1 wr_vld", mem_wr_vld, 0);

    rob_head = 3'd2;
    alloc(3'd3); resolve(3'd3, 8'h10, 8'hA3);
    alloc(3'd5);
    alloc(3'd7); resolve(3'd7, 8'h40, 8'hA7);
    alloc(3'd0); resolve(3'd0, 8'h30, 8'hA0);
    query(3'd6, 8'h11);
    chk("R3 unknown older", ld_grant, 0);
    query(3'd5, 8'h11);
    chk("R3 unknown own slot", ld_grant, 1);
    resolve(3'd5, 8'h50, 8'hA5);

    for (int i = 0; i < NV; i++) begin
      ld_vld = VEC[i][12]; ld_idx = VEC[i][11:9]; ld_addr = VEC[i][8:1];
      @(negedge clk);
      checks++;
      if (ld_grant !== VEC[i][0]) begin
        errors++;
        $display("FAIL R%0d row %0d actual=%0b expected=%0b", VEC[i][16:13], i, ld_grant, VEC[i][0]);
      end
    end

    chk("R6 empty head", mem_wr_vld, 0);
    step(); rob_head = 3'd3; mem_wr_rdy = 0;
    query(3'd4, 8'h10);
    chk("R6 offer", mem_wr_vld, 1);
    chk("R6 addr", mem_wr_addr, 8'h10);
    chk("R6 data", mem_wr_data, 8'hA3);
    chk("R2 blocked before release", ld_grant, 0);
    step(); @(negedge clk);
    chk("R7 held", mem_wr_vld, 1);
    chk("R7 addr stable", mem_wr_addr, 8'h10);
    mem_wr_rdy = 1; step(); mem_wr_rdy = 0; @(negedge clk);
    chk("R7 freed", mem_wr_vld, 0);
    chk("R9 granted after release", ld_grant, 1);

    rob_head = 3'd5; @(negedge clk);
    chk("R6 next head", mem_wr_addr, 8'h50);
    flush = 1; mem_wr_rdy = 1; @(negedge clk);
    chk("R8 no offer in flush", mem_wr_vld, 0);
    step(); flush = 0; @(negedge clk);
    chk("R8 no offer after", mem_wr_vld, 0);
    query(3'd1, 8'h30);
    chk("R8 stores discarded", ld_grant, 1);
    mem_wr_rdy = 0; rob_head = 3'd7; @(negedge clk);
    chk("R8 slot7 gone", mem_wr_vld, 0);

    rob_head = 3'd4; alloc(3'd4); @(negedge clk);
    chk("R6 unresolved head", mem_wr_vld, 0);
    resolve(3'd4, 8'hFE, 8'h5C); @(negedge clk);
    chk("R6 resolved head", mem_wr_vld, 1);
    chk("R6 resolved data", mem_wr_data, 8'h5C);
    query(3'd6, 8'hFF);
    chk("R4 near miss", ld_grant, 1);
    query(3'd6, 8'hFE);
    chk("R2 match", ld_grant, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule